// File: doc/BRIEF.md
# Key-Locked Watchdog Counter

This block is a watchdog timer that sits on a simple 32-bit register bus. Software loads a 32-bit countdown value and sets a control word. While counting is enabled, the counter drops by one on each clock. When it reaches zero, the block records a sticky pending flag and can raise an interrupt, request a system reset, or do both. A reset request also sets a sticky flag that records the watchdog as the reset cause. That flag survives the system reset the block requests and is cleared only by the block's own power-on reset or by software.

The countdown and control registers are write-protected. A write to either of them lands only while the lock is open. Software opens the lock by writing the magic value 0x0000482E to the key register. Writing any other value closes the lock again. The usual reprogramming order is: open the lock, clear the control word, load the timeout (seconds times the tick rate), write the control bits, then close the lock. The key, status and read paths work whether the lock is open or closed.

The bus is register-based, so there is no stream traffic and no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. A read returns data on the edge after `bus_rd` is sampled.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the lock is closed. The control word, count and both status flags are zero, and `wdt_irq` and `wdt_rst_req` are low.
- R2: Writing 0x0000482E to the key offset 0x1C opens the lock, and writing any other value closes it. A read of offset 0x1C returns the lock state in bit 0 (1 = open).
- R3: While the lock is closed, writes to the count offset 0x14 and the control offset 0x18 leave those registers unchanged.
- R4: While control bit 2 (count enable) is set and the count is nonzero, the count drops by one per clock. While bit 2 is clear, the count holds.
- R5: When the count steps from 1 to 0, status bit 3 (pending) sets, and the count then stays at zero.
- R6: `wdt_irq` is high exactly while status bit 3 is set and control bit 1 (interrupt enable) is set.
- R7: If control bit 0 (reset enable) is set when the count steps to zero, `wdt_rst_req` is high for exactly one cycle and status bit 4 (watchdog reset cause) sets. If bit 0 is clear, neither happens.
- R8: Writing 1 to status bit 3 or bit 4 at offset 0x20 clears that bit. Writing 0 leaves it unchanged, and no system reset request clears bit 4.
- R9: A read at offset 0x14 returns the live count, and 0x18 returns the control bits in [2:0]. Data appears on `bus_rdata` one cycle after `bus_rd`.
- R10: A count write while the lock is open and counting is under way reloads the counter. Counting then continues from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wdt_irq | output | 1 | Level interrupt on expiry |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
A register write lands on the edge it is sampled. Counting begins on the edge after the control write. A read issued after k idle cycles therefore returns the loaded value minus k. The pending flag, the reset-cause flag and `wdt_rst_req` all change on the edge where the count reaches zero, which is N edges after the enabling write. The reset request drops one edge later. `wdt_irq` follows the pending flag with no delay. The bench drives inputs on falling edges and samples outputs on falling edges, counting whole cycles from the enabling write to the expected edge.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned OFF_COUNT  = 'h14;
  localparam int unsigned OFF_CTRL   = 'h18;
  localparam int unsigned OFF_KEY    = 'h1C;
  localparam int unsigned OFF_STATUS = 'h20;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_482E;

  localparam int unsigned CTL_RST = 0;
  localparam int unsigned CTL_IRQ = 1;
  localparam int unsigned CTL_CNT = 2;

  localparam int unsigned ST_PEND = 3;
  localparam int unsigned ST_WRST = 4;

  typedef struct packed {
    logic cnt_en;
    logic irq_en;
    logic rst_en;
  } ctl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pend,
  input  logic              wrst,
  output ctl_t              ctl,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr_pend,
  output logic              clr_wrst
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic open_q;
  logic wr_count, wr_ctrl, wr_key, wr_stat;

  always_comb begin
    wr_count = bus_wr && (bus_addr == A_COUNT);
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wr_key   = bus_wr && (bus_addr == A_KEY);
    wr_stat  = bus_wr && (bus_addr == A_STATUS);
  end

  assign load     = wr_count && open_q;
  assign load_val = bus_wdata[CNT_W-1:0];
  assign clr_pend = wr_stat && bus_wdata[ST_PEND];
  assign clr_wrst = wr_stat && bus_wdata[ST_WRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (wr_key) begin
      open_q <= (bus_wdata == UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_ctrl && open_q) begin
      ctl.cnt_en <= bus_wdata[CTL_CNT];
      ctl.irq_en <= bus_wdata[CTL_IRQ];
      ctl.rst_en <= bus_wdata[CTL_RST];
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_COUNT:  rd_mux = DATA_W'(cnt);
      A_CTRL:   rd_mux = DATA_W'({ctl.cnt_en, ctl.irq_en, ctl.rst_en});
      A_KEY:    rd_mux = DATA_W'(open_q);
      A_STATUS: begin
        rd_mux[ST_PEND] = pend;
        rd_mux[ST_WRST] = wrst;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  // R3
  ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !open_q) |=> $stable(ctl));

  // R2
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && bus_wdata != UNLOCK_KEY) |=> !open_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = en && (cnt != '0) && !load;
  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  // R5
  zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  input  logic irq_en,
  input  logic clr_pend,
  input  logic clr_wrst,
  output logic pend,
  output logic wrst,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      wrst    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire && rst_en;
      if (expire)        pend <= 1'b1;
      else if (clr_pend) pend <= 1'b0;
      if (expire && rst_en) wrst <= 1'b1;
      else if (clr_wrst)    wrst <= 1'b0;
    end
  end

  assign irq = pend && irq_en;

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wrst);

  // R6
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  // R5
  pend_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  ctl_t             ctl;
  logic             load, clr_pend, clr_wrst, pend, wrst, expire;
  logic [CNT_W-1:0] load_val, cnt;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .pend(pend), .wrst(wrst), .ctl(ctl), .load(load),
    .load_val(load_val), .clr_pend(clr_pend), .clr_wrst(clr_wrst)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctl.cnt_en), .load(load),
    .load_val(load_val), .cnt(cnt), .expire(expire)
  );

  wdt_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(ctl.rst_en),
    .irq_en(ctl.irq_en), .clr_pend(clr_pend), .clr_wrst(clr_wrst),
    .pend(pend), .wrst(wrst), .irq(wdt_irq), .rst_req(wdt_rst_req)
  );
endmodule

// File: tb/sim_wdt_keyed.sv
module sim_wdt_keyed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_irq, wdt_rst_req;
  int checks = 0, errors = 0;
  logic [31:0] v, v2;

  localparam logic [5:0] A_CNT = 6'h14, A_CTL = 6'h18, A_KEY = 6'h1C, A_ST = 6'h20;
  localparam logic [31:0] KEY = 32'h0000_482E;

  always #5 clk = ~clk;

  wdt_keyed u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(A_KEY, v); chk(v == 0, "R1 key", v, 0);
    rd(A_CTL, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(A_CNT, v); chk(v == 0, "R1 count", v, 0);
    rd(A_ST, v);  chk(v == 0, "R1 status", v, 0);
    chk(!wdt_irq && !wdt_rst_req, "R1 outputs", {wdt_irq, wdt_rst_req}, 0);
  endtask

  task automatic t_lock;
    wr(A_CNT, 32'd77);
    wr(A_CTL, 32'd4);
    rd(A_CNT, v); chk(v == 0, "R3 count locked", v, 0);
    rd(A_CTL, v); chk(v == 0, "R3 ctrl locked", v, 0);
    wr(A_KEY, KEY);
    rd(A_KEY, v); chk(v == 1, "R2 open", v, 1);
    wr(A_KEY, 32'h0000_482F);
    rd(A_KEY, v); chk(v == 0, "R2 near key closes", v, 0);
    wr(A_KEY, KEY);
    wr(A_CTL, 32'd0);
    wr(A_CNT, 32'd1000);
    wr(A_KEY, 32'd0);
    rd(A_KEY, v); chk(v == 0, "R2 zero closes", v, 0);
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); chk(v == 1000, "R3 count write ignored", v, 1000);
  endtask

  task automatic t_count;
    wr(A_KEY, KEY);
    wr(A_CNT, 32'd100);
    wr(A_CTL, 32'd4);
    idle(10);
    rd(A_CNT, v); chk(v == 90, "R4 decrement", v, 90);
    rd(A_CTL, v); chk(v == 4, "R9 ctrl read", v, 4);
    wr(A_CNT, 32'd50);
    rd(A_CNT, v); chk(v == 50, "R10 reload", v, 50);
    wr(A_CTL, 32'd0);
    rd(A_CNT, v);
    idle(5);
    rd(A_CNT, v2); chk(v2 == v, "R4 hold", v2, v);
    wr(A_KEY, 32'd0);
    wr(A_CTL, 32'd4);
    rd(A_CNT, v2); chk(v2 == v, "R3 ctrl write ignored", v2, v);
  endtask

  task automatic t_expire_rst;
    wr(A_KEY, KEY);
    wr(A_CTL, 32'd0);
    wr(A_CNT, 32'd20);
    wr(A_CTL, 32'd7);
    idle(19);
    chk(!wdt_rst_req && !wdt_irq, "R7 not early", {wdt_irq, wdt_rst_req}, 0);
    idle(1);
    chk(wdt_rst_req == 1, "R7 rst pulse", wdt_rst_req, 1);
    chk(wdt_irq == 1, "R6 irq", wdt_irq, 1);
    idle(1);
    chk(wdt_rst_req == 0, "R7 single cycle", wdt_rst_req, 0);
    rd(A_ST, v); chk(v == 32'h18, "R5 R7 status", v, 32'h18);
    rd(A_CNT, v); chk(v == 0, "R5 stays zero", v, 0);
    wr(A_ST, 32'h0);
    rd(A_ST, v); chk(v == 32'h18, "R8 zero write", v, 32'h18);
    wr(A_ST, 32'h08);
    rd(A_ST, v); chk(v == 32'h10, "R8 clear pend", v, 32'h10);
    chk(wdt_irq == 0, "R6 irq drops", wdt_irq, 0);
    wr(A_ST, 32'h10);
    rd(A_ST, v); chk(v == 0, "R8 clear cause", v, 0);
  endtask

  task automatic t_expire_irq_only;
    logic seen;
    seen = 1'b0;
    wr(A_CTL, 32'd0);
    wr(A_CNT, 32'd5);
    wr(A_CTL, 32'd2);
    rd(A_ST, v); chk(v == 0, "R6 pend clear before", v, 0);
    chk(wdt_irq == 0, "R6 no irq before expiry", wdt_irq, 0);
    wr(A_CTL, 32'd6);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wdt_rst_req) seen = 1'b1;
    end
    chk(!seen, "R7 no rst without enable", seen, 0);
    chk(wdt_irq == 1, "R6 irq only", wdt_irq, 1);
    rd(A_ST, v); chk(v == 32'h08, "R7 no cause flag", v, 32'h08);
    wr(A_CTL, 32'd4);
    chk(wdt_irq == 0, "R6 irq masked", wdt_irq, 0);
    wr(A_ST, 32'h08);
  endtask

  task automatic t_cause_sticky;
    wr(A_CTL, 32'd0);
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'd5);
    idle(4);
    rd(A_ST, v); chk(v[4] == 1, "R8 cause survives request", v, 32'h18);
    idle(3);
    rd(A_ST, v); chk(v[4] == 1, "R8 cause still set", v, 32'h18);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_lock;
        t_count;
        t_expire_rst;
        t_expire_irq_only;
        t_cause_sticky;
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule